// File: doc/BRIEF.md
# Local Bus Deadlock Backoff Controller

This block settles a deadlock on a shared local bus. A bridge that serves PCI slave accesses may need that bus while a local master holds it and waits on the bridge. While the bridge is requesting the bus and no grant is present, a wait counter runs. If it reaches a programmed count before the grant arrives, the block raises a backoff request to the external arbiter. It also withholds ready from the local master, so that the master's current data beat goes unacknowledged. Once the arbiter grants the bus, the bridge finishes its access and releases the bus, and the backoff request drops.

The block records the address and direction of the local master's cycle and counts the beats it has acknowledged in that cycle. When the master restarts with a new address strobe, the block compares the restart against the recorded cycle. On a match the beat count carries on from the first beat that was not acknowledged. If the matching cycle is a read, and a PCI read completed during the backoff, the block hands over the buffered data and issues no second fetch. A restart that does not match is treated as a new cycle, and a read issues a fresh fetch.

Top module: `lbBackoffTop`

## Requirements
- R1: After reset, backoffReq is 0 and beatIdx is 0.
- R2: backoffReq rises at the clock edge that ends the cfgTimeout-th consecutive cycle with bridgeReq=1, busGrant=0 and bridgeDone=0. A cycle with busGrant=1 restarts the count.
- R3: While backoffReq is 1, busGrant=1 keeps it at 1 as long as bridgeReq stays 1 and bridgeDone stays 0.
- R4: lmReady equals lmBeat AND sinkOk while backoffReq is 0, and it is 0 while backoffReq is 1.
- R5: bridgeGo is 1 exactly when bridgeReq and busGrant are both 1.
- R6: A clock edge with bridgeDone=1 or bridgeReq=0 clears backoffReq.
- R7: An accepted address strobe that starts a new cycle sets beatIdx to 1 if lmReady is 1 in the same cycle and to 0 otherwise. Each later cycle with lmReady=1 increments beatIdx.
- R8: The first accepted strobe after a backoff matches the recorded cycle when lmAddr and lmWrite (1 = write) equal those of that cycle. On a match, resumeHit is 1 and beatIdx keeps its value, so counting resumes at the first unacknowledged beat.
- R9: On a matching read restart (lmWrite=0), when pciRdDone was 1 during the backoff, rdReuse is 1 and rdFetch is 0.
- R10: An accepted read strobe that does not resume held data gives rdFetch=1. A non-matching restart gives resumeHit=0 and resets beatIdx.
- R11: An address strobe while backoffReq is 1 is ignored: rdFetch, rdReuse and resumeHit stay 0, and beatIdx does not change.
- R12: With cfgTimeout equal to 0, backoffReq never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgTimeout | input | TW | Grant-wait limit in cycles; 0 disables backoff |
| bridgeReq | input | 1 | Bridge requests the local bus |
| busGrant | input | 1 | Local bus granted to the bridge |
| bridgeDone | input | 1 | Bridge access finished, bus released |
| pciRdDone | input | 1 | PCI read data arrived in the buffer |
| lmAds | input | 1 | Local master address strobe |
| lmAddr | input | AW | Local master address |
| lmWrite | input | 1 | Local master direction, 1 = write |
| lmBeat | input | 1 | Local master offers a data beat |
| sinkOk | input | 1 | Buffer can take or supply the beat |
| backoffReq | output | 1 | Backoff request to the arbiter |
| bridgeGo | output | 1 | Bridge may run its access |
| lmReady | output | 1 | Ready to the local master |
| beatIdx | output | BW | Beats acknowledged in the current cycle |
| resumeHit | output | 1 | Restart matches the backed-off cycle |
| rdFetch | output | 1 | Issue a new read for this strobe |
| rdReuse | output | 1 | Return the buffered read data |

## Verification
A wait counter that is off by one moves the rise of backoffReq by one cycle, and the test catches that at the exact edge. A stale resume flag or held-read flag shows on the combinational strobe outputs in the same cycle as the restart strobe: a wrong fetch, a missing reuse or a missing resume. A corrupted beat count shows on beatIdx one edge after the restart, when it should have kept its value but was reset or incremented.

// File: rtl/lbBackoffPkg.sv
package lbBackoffPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic newCycle;
    logic beatAck;
  } lbStrb_t;
endpackage

// File: rtl/lbBackoffCtl.sv
module lbBackoffCtl
  import lbBackoffPkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [TW-1:0] cfgTimeout,
  input  logic          bridgeReq,
  input  logic          busGrant,
  input  logic          bridgeDone,
  input  logic          pciRdDone,
  input  logic          lmAds,
  input  logic          lmWrite,
  input  logic          lmBeat,
  input  logic          sinkOk,
  input  logic          cycMatch,
  output logic          backoffReq,
  output logic          bridgeGo,
  output logic          lmReady,
  output logic          resumeHit,
  output logic          rdFetch,
  output logic          rdReuse,
  output lbStrb_t       strb
);
  logic [TW-1:0] waitCnt;
  logic [TW-1:0] lastCnt;
  logic          timerOn;
  logic          expire;
  logic          adsLive;
  logic          resumePend;
  logic          rdHeld;

  assign lastCnt = cfgTimeout - {{(TW-1){1'b0}}, 1'b1};
  assign timerOn = (cfgTimeout != '0) && bridgeReq && !busGrant && !bridgeDone;
  assign expire  = timerOn && !backoffReq && (waitCnt == lastCnt);
  assign adsLive = lmAds && !backoffReq;

  assign bridgeGo  = bridgeReq && busGrant;
  assign lmReady   = lmBeat && sinkOk && !backoffReq;
  assign resumeHit = adsLive && resumePend && cycMatch;
  assign rdReuse   = resumeHit && !lmWrite && rdHeld;
  assign rdFetch   = adsLive && !lmWrite && !(resumeHit && rdHeld);

  assign strb.newCycle = adsLive && !resumeHit;
  assign strb.beatAck  = lmReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt    <= '0;
      backoffReq <= 1'b0;
      resumePend <= 1'b0;
      rdHeld     <= 1'b0;
    end else begin
      if (bridgeDone || !bridgeReq) backoffReq <= 1'b0;
      else if (expire)              backoffReq <= 1'b1;

      if (!timerOn || backoffReq || expire) waitCnt <= '0;
      else                                  waitCnt <= waitCnt + 1'b1;

      if (expire)       resumePend <= 1'b1;
      else if (adsLive) resumePend <= 1'b0;

      if (adsLive)                      rdHeld <= 1'b0;
      else if (pciRdDone && backoffReq) rdHeld <= 1'b1;
    end
  end
endmodule

// File: rtl/lbBackoffDp.sv
module lbBackoffDp
  import lbBackoffPkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  lbStrb_t       strb,
  input  logic [AW-1:0] lmAddr,
  input  logic          lmWrite,
  output logic          cycMatch,
  output logic [BW-1:0] beatIdx
);
  logic [AW-1:0] savedAddr;
  logic          savedWr;

  assign cycMatch = (lmAddr == savedAddr) && (lmWrite == savedWr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedAddr <= '0;
      savedWr   <= 1'b0;
      beatIdx   <= '0;
    end else if (strb.newCycle) begin
      savedAddr <= lmAddr;
      savedWr   <= lmWrite;
      beatIdx   <= {{(BW-1){1'b0}}, strb.beatAck};
    end else if (strb.beatAck) begin
      beatIdx <= beatIdx + 1'b1;
    end
  end
endmodule

// File: rtl/lbBackoffTop.sv
module lbBackoffTop
  import lbBackoffPkg::*;
#(
  parameter int TW = 8,
  parameter int AW = 16,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [TW-1:0] cfgTimeout,
  input  logic          bridgeReq,
  input  logic          busGrant,
  input  logic          bridgeDone,
  input  logic          pciRdDone,
  input  logic          lmAds,
  input  logic [AW-1:0] lmAddr,
  input  logic          lmWrite,
  input  logic          lmBeat,
  input  logic          sinkOk,
  output logic          backoffReq,
  output logic          bridgeGo,
  output logic          lmReady,
  output logic [BW-1:0] beatIdx,
  output logic          resumeHit,
  output logic          rdFetch,
  output logic          rdReuse
);
  lbStrb_t strb;
  logic    cycMatch;

  lbBackoffCtl #(.TW(TW)) u_ctl (
    .clk(clk), .rstN(rstN), .cfgTimeout(cfgTimeout),
    .bridgeReq(bridgeReq), .busGrant(busGrant), .bridgeDone(bridgeDone),
    .pciRdDone(pciRdDone), .lmAds(lmAds), .lmWrite(lmWrite),
    .lmBeat(lmBeat), .sinkOk(sinkOk), .cycMatch(cycMatch),
    .backoffReq(backoffReq), .bridgeGo(bridgeGo), .lmReady(lmReady),
    .resumeHit(resumeHit), .rdFetch(rdFetch), .rdReuse(rdReuse),
    .strb(strb)
  );

  lbBackoffDp #(.AW(AW), .BW(BW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lmAddr(lmAddr),
    .lmWrite(lmWrite), .cycMatch(cycMatch), .beatIdx(beatIdx)
  );
endmodule

// File: rtl/lbBackoffChk.sv
module lbBackoffChk #(
  parameter int TW = 8,
  parameter int BW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic [TW-1:0] cfgTimeout,
  input logic          bridgeReq,
  input logic          busGrant,
  input logic          bridgeDone,
  input logic          lmAds,
  input logic          lmWrite,
  input logic          backoffReq,
  input logic          lmReady,
  input logic [BW-1:0] beatIdx,
  input logic          resumeHit,
  input logic          rdFetch,
  input logic          rdReuse
);
  // R4
  no_ready_in_backoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    backoffReq |-> !lmReady);
  // R2
  rise_needs_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(backoffReq) |-> ($past(bridgeReq) && !$past(busGrant)));
  // R6
  done_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    bridgeDone |=> !backoffReq);
  // R12
  zero_disables_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgTimeout == '0 && !backoffReq) |=> !backoffReq);
  // R11
  ads_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lmAds && backoffReq) |-> (!rdFetch && !rdReuse && !resumeHit));
  // R9
  reuse_is_resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReuse |-> (resumeHit && !lmWrite && !rdFetch));
  // R8
  resume_keeps_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resumeHit && !lmReady) |=> (beatIdx == $past(beatIdx)));
  // R3
  grant_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (backoffReq && bridgeReq && !bridgeDone) |=> backoffReq);
endmodule

bind lbBackoffTop lbBackoffChk #(.TW(TW), .BW(BW)) u_chk (
  .clk(clk), .rstN(rstN), .cfgTimeout(cfgTimeout), .bridgeReq(bridgeReq),
  .busGrant(busGrant), .bridgeDone(bridgeDone), .lmAds(lmAds),
  .lmWrite(lmWrite), .backoffReq(backoffReq), .lmReady(lmReady),
  .beatIdx(beatIdx), .resumeHit(resumeHit), .rdFetch(rdFetch),
  .rdReuse(rdReuse)
);

// File: tb/lbBackoffTop_tb.sv
module lbBackoffTop_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cfgTimeout = '0;
  logic        bridgeReq = 0, busGrant = 0, bridgeDone = 0, pciRdDone = 0;
  logic        lmAds = 0, lmWrite = 0, lmBeat = 0, sinkOk = 0;
  logic [15:0] lmAddr = '0;
  logic        backoffReq, bridgeGo, lmReady, resumeHit, rdFetch, rdReuse;
  logic [3:0]  beatIdx;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lbBackoffTop u_dut (
    .clk(clk), .rstN(rstN), .cfgTimeout(cfgTimeout), .bridgeReq(bridgeReq),
    .busGrant(busGrant), .bridgeDone(bridgeDone), .pciRdDone(pciRdDone),
    .lmAds(lmAds), .lmAddr(lmAddr), .lmWrite(lmWrite), .lmBeat(lmBeat),
    .sinkOk(sinkOk), .backoffReq(backoffReq), .bridgeGo(bridgeGo),
    .lmReady(lmReady), .beatIdx(beatIdx), .resumeHit(resumeHit),
    .rdFetch(rdFetch), .rdReuse(rdReuse)
  );

  // {cfg[7:0], req, grant, done, expected backoffReq after the edge}
  localparam int NV = 17;
  localparam logic [11:0] VEC [NV] = '{
    {8'd3, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'd3, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'd3, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'd3, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'd3, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'd3, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'd3, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'd3, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'd3, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'd3, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'd3, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'd3, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'd1, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'd1, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance to one time unit after the next rising edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    eq("R1 backoffReq", backoffReq, 0);
    eq("R1 beatIdx", beatIdx, 0);
    rstN = 1'b1;
    lmBeat = 1'b1; sinkOk = 1'b1;

    // timer vectors: R2 R3 R6 R12, with R4 on lmReady
    for (int i = 0; i < NV; i++) begin
      cfgTimeout = VEC[i][11:4];
      bridgeReq  = VEC[i][3];
      busGrant   = VEC[i][2];
      bridgeDone = VEC[i][1];
      tick();
      eq($sformatf("R2/R3/R6/R12 vec%0d backoffReq", i), backoffReq, VEC[i][0]);
      eq($sformatf("R4 vec%0d lmReady", i), lmReady, !VEC[i][0]);
    end
    bridgeReq = 0; busGrant = 0; bridgeDone = 0; lmBeat = 0;

    // R5
    bridgeReq = 1; busGrant = 1; #1;
    eq("R5 bridgeGo", bridgeGo, 1);
    busGrant = 0; #1;
    eq("R5 bridgeGo no grant", bridgeGo, 0);
    bridgeReq = 0;
    tick();

    // R7 write cycle, ack in same cycle as strobe
    lmAds = 1; lmAddr = 16'h0040; lmWrite = 1; lmBeat = 1;
    tick();
    eq("R7 first beat", beatIdx, 1);
    lmAds = 0;
    tick(); tick();
    eq("R7 three beats", beatIdx, 3);
    lmBeat = 0; cfgTimeout = 8'd2; bridgeReq = 1;
    tick(); tick();
    eq("R2 backoff cfg2", backoffReq, 1);
    lmBeat = 1; #1;
    eq("R4 ready suppressed", lmReady, 0);
    // R11 strobe during backoff
    lmAds = 1; lmAddr = 16'h0080; lmWrite = 0; #1;
    eq("R11 rdFetch", rdFetch, 0);
    eq("R11 resumeHit", resumeHit, 0);
    tick();
    eq("R11 beatIdx kept", beatIdx, 3);
    lmAds = 0; lmBeat = 0; busGrant = 1; bridgeDone = 1;
    tick();
    eq("R6 done clears", backoffReq, 0);
    bridgeReq = 0; busGrant = 0; bridgeDone = 0;
    // R8 matching restart
    lmAds = 1; lmAddr = 16'h0040; lmWrite = 1; #1;
    eq("R8 resumeHit", resumeHit, 1);
    eq("R8 rdFetch", rdFetch, 0);
    tick();
    eq("R8 beatIdx kept", beatIdx, 3);
    lmAds = 0; lmBeat = 1;
    tick();
    eq("R8 next beat", beatIdx, 4);
    lmBeat = 0;

    // R9 read resume with held data
    lmAds = 1; lmAddr = 16'h0100; lmWrite = 0; #1;
    eq("R10 fresh read fetch", rdFetch, 1);
    tick();
    eq("R7 new cycle idx", beatIdx, 0);
    lmAds = 0; cfgTimeout = 8'd1; bridgeReq = 1;
    tick();
    eq("R2 backoff cfg1", backoffReq, 1);
    pciRdDone = 1;
    tick();
    pciRdDone = 0; busGrant = 1; bridgeDone = 1;
    tick();
    bridgeReq = 0; busGrant = 0; bridgeDone = 0;
    lmAds = 1; lmAddr = 16'h0100; lmWrite = 0; #1;
    eq("R9 rdReuse", rdReuse, 1);
    eq("R9 rdFetch", rdFetch, 0);
    eq("R9 resumeHit", resumeHit, 1);
    tick();
    lmAds = 0;

    // R10 mismatched restart
    lmAds = 1; lmAddr = 16'h0200; lmWrite = 0; lmBeat = 1;
    tick();
    lmAds = 0; lmBeat = 0; bridgeReq = 1;
    tick();
    pciRdDone = 1;
    tick();
    pciRdDone = 0; busGrant = 1; bridgeDone = 1;
    tick();
    bridgeReq = 0; busGrant = 0; bridgeDone = 0;
    eq("R10 pre beatIdx", beatIdx, 1);
    lmAds = 1; lmAddr = 16'h0204; lmWrite = 0; #1;
    eq("R10 rdFetch", rdFetch, 1);
    eq("R10 rdReuse", rdReuse, 0);
    eq("R10 resumeHit", resumeHit, 0);
    tick();
    eq("R10 beatIdx reset", beatIdx, 0);
    lmAds = 0;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule